// File: doc/BRIEF.md
# Colour Subcarrier Phase Oscillator

This block is a numerically controlled oscillator that produces the running colour subcarrier phase for a composite video encoder. A 32-bit accumulator advances by a programmable step, the frequency word, on every pixel clock and wraps freely. The upper eight accumulator bits are added to an eight-bit phase trim and become the phase word that addresses a downstream sine table. The sine table, the chroma modulator and the host bus are outside this block.

The frequency word is loaded one byte at a time through a simple write port: a strobe, a slot index and a data byte. Byte writes land in a staging copy. The running step changes only when all four byte slots have been written since the last change, so the oscillator never runs on a mix of old and new bytes. The step is round(2^32 x subcarrier cycles per line / clock cycles per line). For a 525-line system on a 27 MHz clock (227.5 cycles over 1716 clocks) that gives 0x21F07C1F. Out of reset the step is 0x21F07C16, which differs from that value only in its lowest byte. The trim is written through its own slot and acts at once. Each LSB is 360/256 degrees, about 1.41 degrees, and 0x00 means no trim.

Top module: `subcarrier_nco`

## Requirements
- R1: While rst_n is low the accumulator is zero, the trim is zero and phase_o reads 0x00. The reset step is 0x21F07C16, so one clock after release phase_o is 0x21 and after two clocks it is 0x43.
- R2: On every rising clock edge with rst_n high the accumulator takes the sum of its old value and the step in force before that edge. phase_o is always the top eight accumulator bits plus the trim.
- R3: Slot k, for k from 0 to 3, holds step bits 8k+7 down to 8k, so slot 3 is the most significant byte.
- R4: A write to a step slot changes only the staging copy while any of the four slots is still unwritten since the last change. The running step stays as it was.
- R5: The write that completes the set of four slots loads the staged word in the same edge. The accumulator steps by the old word at that edge and by the new word from the next edge on. The set then starts empty again, and the slots may be written in any order.
- R6: A write to slot 4 sets the trim. phase_o includes the new trim right after that edge, and the sum wraps modulo 256.
- R7: Writes to slots 5, 6 and 7 change neither the step, the staging copy nor the trim.
- R8: The accumulator wraps modulo 2^32 without saturating.
- R9: Writing one step slot twice before the set is complete keeps the last byte written and counts that slot once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe, one write per cycle |
| wr_idx | input | 3 | Slot index: 0 to 3 step bytes, 4 trim, 5 to 7 unused |
| wr_data | input | 8 | Byte to write |
| phase_o | output | 8 | Subcarrier phase word |

## Verification
The first patterns are the reset step and a unit step of 0x01000000. Their fixed, hand-computed phase sequences separate a wrong reset word or a wrong byte lane from a wrong accumulation. Partial step updates, slots written in scrambled order and repeated slot writes check that the running step changes only on the fourth distinct slot and only one edge later. An all-ones step and a large trim push the accumulator and the phase sum across their wrap points. A long random mix of writes to all eight slots, compared cycle by cycle against a reference model, brings out writes to unused slots that leak into the step, the staging copy or the trim.

// File: rtl/nco_pkg.sv
package nco_pkg;
   localparam int unsigned DEF_ACC_W  = 32;
   localparam int unsigned DEF_BYTE_W = 8;
   localparam int unsigned DEF_IDX_W  = 3;
   localparam logic [31:0] DEF_INIT_STEP = 32'h21F0_7C16;
endpackage

// File: rtl/nco_step_regs.sv
module nco_step_regs #(
   parameter int unsigned ACC_W  = nco_pkg::DEF_ACC_W,
   parameter int unsigned BYTE_W = nco_pkg::DEF_BYTE_W,
   parameter int unsigned IDX_W  = nco_pkg::DEF_IDX_W,
   parameter logic [ACC_W-1:0] INIT_STEP = ACC_W'(nco_pkg::DEF_INIT_STEP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [ACC_W-1:0]  step_o
);
   localparam int unsigned LANES = ACC_W / BYTE_W;

   logic [LANES-1:0] lane_hit;
   logic [LANES-1:0] seen_q, seen_d;
   logic [ACC_W-1:0] stage_q, stage_d, step_q;
   logic             load_now;

   // one staging lane per byte slot
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_hit[g] = wr_en && (wr_idx == IDX_W'(g));
      assign stage_d[g*BYTE_W +: BYTE_W] =
         lane_hit[g] ? wr_data : stage_q[g*BYTE_W +: BYTE_W];
   end

   assign seen_d   = seen_q | lane_hit;
   assign load_now = &seen_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= INIT_STEP;
         step_q  <= INIT_STEP;
         seen_q  <= '0;
      end else begin
         stage_q <= stage_d;
         if (load_now) begin
            step_q <= stage_d;
            seen_q <= '0;
         end else begin
            seen_q <= seen_d;
         end
      end
   end

   assign step_o = step_q;
endmodule

// File: rtl/nco_trim_reg.sv
module nco_trim_reg #(
   parameter int unsigned BYTE_W = nco_pkg::DEF_BYTE_W,
   parameter int unsigned IDX_W  = nco_pkg::DEF_IDX_W,
   parameter int unsigned SLOT   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] trim_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         trim_o <= '0;
      else if (wr_en && (wr_idx == IDX_W'(SLOT)))
         trim_o <= wr_data;
   end
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
   parameter int unsigned ACC_W = nco_pkg::DEF_ACC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] step_i,
   output logic [ACC_W-1:0] acc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_o <= '0;
      else
         acc_o <= acc_o + step_i;
   end
endmodule

// File: rtl/nco_phase_sum.sv
module nco_phase_sum #(
   parameter int unsigned ACC_W = nco_pkg::DEF_ACC_W,
   parameter int unsigned PH_W  = nco_pkg::DEF_BYTE_W
) (
   input  logic [ACC_W-1:0] acc_i,
   input  logic [PH_W-1:0]  trim_i,
   output logic [PH_W-1:0]  phase_o
);
   localparam int unsigned SHIFT = ACC_W - PH_W;

   assign phase_o = PH_W'(acc_i >> SHIFT) + trim_i;
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco #(
   parameter int unsigned ACC_W  = nco_pkg::DEF_ACC_W,
   parameter int unsigned BYTE_W = nco_pkg::DEF_BYTE_W,
   parameter int unsigned IDX_W  = nco_pkg::DEF_IDX_W,
   parameter logic [ACC_W-1:0] INIT_STEP = ACC_W'(nco_pkg::DEF_INIT_STEP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] phase_o
);
   localparam int unsigned LANES     = ACC_W / BYTE_W;
   localparam int unsigned TRIM_SLOT = LANES;

   initial begin
      assert (ACC_W % BYTE_W == 0)
         else $error("accumulator width must be a whole number of bytes");
      assert ((1 << IDX_W) > TRIM_SLOT)
         else $error("slot index too narrow for step bytes plus trim");
      assert (ACC_W > BYTE_W)
         else $error("accumulator must be wider than the phase word");
   end

   logic [ACC_W-1:0]  step_word;
   logic [ACC_W-1:0]  acc_q;
   logic [BYTE_W-1:0] trim_q;

   nco_step_regs #(
      .ACC_W(ACC_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W), .INIT_STEP(INIT_STEP)
   ) i_step (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .step_o(step_word)
   );

   nco_trim_reg #(
      .BYTE_W(BYTE_W), .IDX_W(IDX_W), .SLOT(TRIM_SLOT)
   ) i_trim (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .trim_o(trim_q)
   );

   nco_accum #(.ACC_W(ACC_W)) i_acc (
      .clk(clk), .rst_n(rst_n), .step_i(step_word), .acc_o(acc_q)
   );

   nco_phase_sum #(.ACC_W(ACC_W), .PH_W(BYTE_W)) i_sum (
      .acc_i(acc_q), .trim_i(trim_q), .phase_o(phase_o)
   );
endmodule

// File: rtl/nco_checker.sv
module nco_checker #(
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [BYTE_W-1:0] wr_data,
   input logic [ACC_W-1:0]  acc_q,
   input logic [ACC_W-1:0]  step_word,
   input logic [BYTE_W-1:0] trim_q,
   input logic [BYTE_W-1:0] phase_o
);
   localparam int unsigned LANES = ACC_W / BYTE_W;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (acc_q == '0) && (phase_o == '0));

   // R2 R8
   acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> acc_q == $past(acc_q) + $past(step_word));

   // R4
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_idx < IDX_W'(LANES))) |=> $stable(step_word));

   // R6
   trim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx == IDX_W'(LANES))) |=> trim_q == $past(wr_data));

   // R6
   trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_idx == IDX_W'(LANES))) |=> $stable(trim_q));

   // R7
   spare_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx > IDX_W'(LANES))) |=> $stable(step_word) && $stable(trim_q));
endmodule

bind subcarrier_nco nco_checker #(
   .ACC_W(ACC_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)
) i_nco_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
   .wr_data(wr_data), .acc_q(acc_q), .step_word(step_word),
   .trim_q(trim_q), .phase_o(phase_o)
);

// File: tb/test_subcarrier_nco.sv
`timescale 1ns/1ps
module test_subcarrier_nco;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_idx = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] phase_o;

   subcarrier_nco i_subcarrier_nco (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .phase_o(phase_o)
   );

   always #2.5 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // reference model state
   logic [31:0] m_acc, m_step, m_stage;
   logic [3:0]  m_seen;
   logic [7:0]  m_trim;

   function automatic logic [7:0] model_phase();
      return m_acc[31:24] + m_trim;
   endfunction

   task automatic model_reset();
      m_acc = '0; m_step = 32'h21F0_7C16; m_stage = 32'h21F0_7C16;
      m_seen = '0; m_trim = '0;
   endtask

   task automatic model_edge(bit en, logic [2:0] idx, logic [7:0] d);
      m_acc = m_acc + m_step;
      if (en) begin
         if (idx < 3'd4) begin
            m_stage[idx*8 +: 8] = d;
            m_seen[idx] = 1'b1;
            if (&m_seen) begin
               m_step = m_stage;
               m_seen = '0;
            end
         end else if (idx == 3'd4) begin
            m_trim = d;
         end
      end
   endtask

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: phase=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   // called just after a falling edge; ends just after the next falling edge
   task automatic cycle(bit en, logic [2:0] idx, logic [7:0] d, string req);
      wr_en = en; wr_idx = idx; wr_data = d;
      @(posedge clk);
      model_edge(en, idx, d);
      @(negedge clk);
      wr_en = 1'b0;
      check(req, phase_o, model_phase());
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_en = 1'b0;
      model_reset();
      @(negedge clk);
      check("R1", phase_o, 8'h00);
      rst_n = 1'b1;
   endtask

   task automatic idle(int n, string req);
      for (int i = 0; i < n; i++) cycle(1'b0, 3'd0, 8'h00, req);
   endtask

   initial begin
      logic [7:0] prev;
      void'($urandom(32'd20240611));
      model_reset();
      @(negedge clk);
      @(negedge clk);
      check("R1", phase_o, 8'h00);
      rst_n = 1'b1;

      // R1: reset step, literal values
      cycle(1'b0, 3'd0, 8'h00, "R1");
      check("R1", phase_o, 8'h21);
      cycle(1'b0, 3'd0, 8'h00, "R1");
      check("R1", phase_o, 8'h43);
      idle(5, "R2");

      // R4: partial writes leave the step alone
      cycle(1'b1, 3'd0, 8'h1F, "R4");
      idle(3, "R4");
      cycle(1'b1, 3'd1, 8'h7C, "R4");
      cycle(1'b1, 3'd2, 8'hF0, "R4");
      idle(3, "R4");
      // R5: completing write; old step used at that edge
      cycle(1'b1, 3'd3, 8'h21, "R5");
      idle(6, "R5");

      // R3: unit step in top byte, phase advances by one each clock
      do_reset();
      cycle(1'b1, 3'd2, 8'h00, "R3");
      cycle(1'b1, 3'd0, 8'h00, "R3");
      cycle(1'b1, 3'd3, 8'h01, "R3");
      cycle(1'b1, 3'd1, 8'h00, "R5");
      prev = phase_o;
      for (int i = 0; i < 8; i++) begin
         cycle(1'b0, 3'd0, 8'h00, "R3");
         check("R3", phase_o - prev, 8'h01);
         prev = phase_o;
      end

      // R9: repeated slot write, last value kept, counted once
      do_reset();
      cycle(1'b1, 3'd0, 8'h55, "R9");
      cycle(1'b1, 3'd0, 8'h00, "R9");
      cycle(1'b1, 3'd1, 8'h00, "R9");
      cycle(1'b1, 3'd1, 8'h00, "R9");
      cycle(1'b1, 3'd2, 8'h00, "R9");
      idle(2, "R9");
      cycle(1'b1, 3'd3, 8'h02, "R9");
      prev = phase_o;
      cycle(1'b0, 3'd0, 8'h00, "R9");
      check("R9", phase_o - prev, 8'h02);

      // R6: trim applied at once, wraps modulo 256
      cycle(1'b1, 3'd4, 8'hF0, "R6");
      prev = phase_o;
      cycle(1'b1, 3'd4, 8'h80, "R6");
      check("R6", phase_o, prev + 8'h02 + 8'h90);
      idle(4, "R6");
      cycle(1'b1, 3'd4, 8'h00, "R6");

      // R7: spare slots ignored
      cycle(1'b1, 3'd5, 8'hAA, "R7");
      cycle(1'b1, 3'd6, 8'h13, "R7");
      cycle(1'b1, 3'd7, 8'hFF, "R7");
      idle(4, "R7");
      cycle(1'b1, 3'd0, 8'h00, "R7");
      cycle(1'b1, 3'd1, 8'h00, "R7");
      cycle(1'b1, 3'd2, 8'h00, "R7");
      cycle(1'b1, 3'd7, 8'h09, "R7");
      idle(3, "R7");
      cycle(1'b1, 3'd3, 8'h02, "R7");
      idle(3, "R7");

      // R8: all-ones step, accumulator wraps every clock
      do_reset();
      for (int k = 0; k < 4; k++) cycle(1'b1, 3'(k), 8'hFF, "R8");
      idle(20, "R8");
      // R8: big step across many wraps
      for (int k = 3; k >= 0; k--) cycle(1'b1, 3'(k), 8'hC3, "R8");
      idle(40, "R8");

      // R2: random mix of writes
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r = $urandom % 16;
         if (r < 3)
            cycle(1'b1, 3'($urandom % 8), 8'($urandom), "R2");
         else
            cycle(1'b0, 3'd0, 8'h00, "R2");
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: run=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule